// File: doc/BRIEF.md
# Endpoint Inbound Header Router

This block sits behind the receive side of a PCIe endpoint and looks at one transaction-layer header per cycle. From the format/type byte, the destination and requester IDs and the address, it decides where the packet goes. It can go to a configuration function, to a function's completion queue, or to a function as an IO or memory request together with the matching BAR index and that BAR's aperture. Otherwise it is discarded. Where the protocol calls for an answer, the block asks for an Unsupported Request completion or a Configuration Request Retry Status completion instead. Payload bytes never pass through the block.

The router holds the endpoint's bus number. The bus number is captured from every accepted type 0 configuration access that addresses this device. Completions are then matched against it. BAR base and mask values arrive as flat vectors, one 32-bit word per BAR per function. They are compared in parallel, and the result is registered, so the decision appears one cycle after the header.

Top module: `ep_inbound_router`

## Requirements
- R1: After reset, all outputs including `bus_num` are zero. Each decision is presented on the outputs one cycle after `in_valid`, with `out_valid` high for exactly that cycle. In cycles without a header, every output except `bus_num` is zero.
- R2: A type 0 configuration request (format/type 0x04 or 0x44) with the configuration space enabled, whose destination device (`in_dest_id[7:3]`) equals `dev_num`, loads `in_dest_id[15:8]` into `bus_num`. If its function number (`in_dest_id[2:0]`) is below NUM_FUNC, it is routed CONFIG (code 1) with that function; otherwise an Unsupported Request is requested.
- R3: A type 0 configuration request for another device number requests an Unsupported Request and leaves `bus_num` unchanged. No header other than type 0 configuration changes `bus_num`.
- R4: A type 0 configuration request while `cfg_space_en` is low requests a retry-status completion (`out_gen_crs`), with route DROP (code 0) and `bus_num` unchanged.
- R5: A type 1 configuration request (0x05 or 0x45) is routed MALFORMED (code 5) and requests no completion.
- R6: A completion (0x0A, 0x4A, 0x0B or 0x4B) whose requester bus (`in_req_id[15:8]`) equals `bus_num`, whose requester device (`in_req_id[7:3]`) equals `dev_num`, and whose requester function is below NUM_FUNC is routed CPL (code 2) to that function. Any other completion is routed DROP, and a completion never requests an Unsupported Request.
- R7: A routed completion raises `out_bad_status` exactly when its status field is nonzero (0 means successful).
- R8: IO requests (0x02, 0x42) match only BARs with base bit 0 set and are routed IO (code 3). Memory requests (0x00, 0x20, 0x40, 0x60) match only BARs with base bit 0 clear and are routed MEM (code 4). The function and BAR index are output. A BAR is enabled when its mask is nonzero. It hits when (address & mask) equals (base & mask), with base bits [1:0] (IO) or [3:0] (memory) ignored; a 32-bit BAR also needs address bits 63:32 to be zero.
- R9: When several BARs hit, the lowest function wins, and within it the lowest BAR index wins.
- R10: A memory BAR with base bits [2:1] = 10 is 64-bit. The next BAR supplies bits 63:32 of both its base and its mask, and that next BAR is never matched on its own.
- R11: `out_aperture` is the bit length of the inverted mask of the hit BAR: 64 bits wide for a 64-bit BAR, 32 bits wide otherwise.
- R12: An unmatched memory read or IO request requests an Unsupported Request. An unmatched memory write is routed DROP with no completion request.
- R13: Any other format/type value, including locked memory reads (0x01, 0x21) and messages, requests an Unsupported Request with route DROP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A header is present this cycle |
| in_fmt_type | input | 8 | Format (bits 7:5) and type (bits 4:0) |
| in_dest_id | input | 16 | Destination bus/device/function of configuration requests |
| in_req_id | input | 16 | Requester bus/device/function |
| in_addr | input | 64 | Request address (upper half zero for 32-bit forms) |
| in_cpl_status | input | 3 | Completion status, 0 = successful |
| cfg_space_en | input | 1 | Configuration space accepting requests |
| dev_num | input | 5 | This endpoint's device number |
| bar_base | input | NUM_FUNC*NUM_BAR*32 | BAR base words, function-major |
| bar_mask | input | NUM_FUNC*NUM_BAR*32 | BAR mask words, same layout |
| out_valid | output | 1 | Decision valid |
| out_route | output | 3 | 0 DROP, 1 CONFIG, 2 CPL, 3 IO, 4 MEM, 5 MALFORMED |
| out_func | output | 3 | Target function |
| out_bar | output | $clog2(NUM_BAR) | Index of hit BAR |
| out_aperture | output | 7 | Aperture bit length of hit BAR |
| out_bad_status | output | 1 | Routed completion carried error status |
| out_gen_ur | output | 1 | Request an Unsupported Request completion |
| out_gen_crs | output | 1 | Request a retry-status completion |
| bus_num | output | 8 | Captured bus number |

## Verification
The assertions assume that BAR base and mask words, `dev_num` and `cfg_space_en` stay steady across the cycle in which a header is decided. They also assume the header fields are sampled only while `in_valid` is high. The stimulus meets this by setting the BARs and device number once before reset is released. It passes `cfg_space_en` together with each header, so a level change always lands on a header boundary. The configured BARs overlap across functions and within one function. This gives the priority checks real contention rather than disjoint windows.

// File: rtl/ep_rt_pkg.sv
package ep_rt_pkg;

  typedef enum logic [2:0] {
    RT_DROP      = 3'd0,
    RT_CONFIG    = 3'd1,
    RT_CPL       = 3'd2,
    RT_IO        = 3'd3,
    RT_MEM       = 3'd4,
    RT_MALFORMED = 3'd5
  } route_e;

  typedef enum logic [2:0] {
    K_MRD, K_MWR, K_IO_RD, K_IO_WR, K_CFG0, K_CFG1, K_CPL, K_OTHER
  } kind_e;

  // index of highest set bit plus one, zero for an all-zero word
  function automatic logic [6:0] bit_len64(input logic [63:0] v);
    logic [6:0] r;
    r = '0;
    for (int i = 0; i < 64; i++)
      if (v[i]) r = 7'(i + 1);
    return r;
  endfunction

endpackage

// File: rtl/ep_hdr_decode.sv
module ep_hdr_decode
  import ep_rt_pkg::*;
(
  input  logic [7:0] fmt_type,
  output kind_e      kind
);
  always_comb begin
    case (fmt_type)
      8'h00, 8'h20:               kind = K_MRD;
      8'h40, 8'h60:               kind = K_MWR;
      8'h02:                      kind = K_IO_RD;
      8'h42:                      kind = K_IO_WR;
      8'h04, 8'h44:               kind = K_CFG0;
      8'h05, 8'h45:               kind = K_CFG1;
      8'h0A, 8'h4A, 8'h0B, 8'h4B: kind = K_CPL;
      default:                    kind = K_OTHER;
    endcase
  end
endmodule

// File: rtl/ep_bar_match.sv
module ep_bar_match
  import ep_rt_pkg::*;
#(
  parameter int NUM_BAR = 6,
  parameter int BAR_W   = $clog2(NUM_BAR)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [63:0]             addr,
  input  logic                    want_io,
  input  logic [NUM_BAR*32-1:0]   bases,
  input  logic [NUM_BAR*32-1:0]   masks,
  output logic                    hit,
  output logic [BAR_W-1:0]        idx,
  output logic [6:0]              aperture
);
  logic [NUM_BAR-1:0] is64;
  logic [NUM_BAR-1:0] upper;
  logic [NUM_BAR-1:0] hits;
  logic [6:0]         ap [NUM_BAR];

  genvar i;
  generate
    for (i = 0; i < NUM_BAR; i++) begin : g_bar
      logic [31:0] b_lo, m_lo, b_hi, m_hi;
      logic [63:0] em, eb;
      logic        io_bar, enabled;
      assign b_lo = bases[i*32 +: 32];
      assign m_lo = masks[i*32 +: 32];
      if (i + 1 < NUM_BAR) begin : g_nxt
        assign b_hi = bases[(i+1)*32 +: 32];
        assign m_hi = masks[(i+1)*32 +: 32];
      end else begin : g_last
        assign b_hi = '0;
        assign m_hi = '0;
      end
      assign io_bar  = b_lo[0];
      assign is64[i] = !b_lo[0] && (b_lo[2:1] == 2'b10) && (i + 1 < NUM_BAR);
      always_comb begin
        if (is64[i]) begin
          em = {m_hi, m_lo & 32'hFFFF_FFF0};
          eb = {b_hi, b_lo & 32'hFFFF_FFF0};
        end else if (io_bar) begin
          em = {32'hFFFF_FFFF, m_lo & 32'hFFFF_FFFC};
          eb = {32'h0, b_lo & 32'hFFFF_FFFC};
        end else begin
          em = {32'hFFFF_FFFF, m_lo & 32'hFFFF_FFF0};
          eb = {32'h0, b_lo & 32'hFFFF_FFF0};
        end
      end
      assign enabled = is64[i] ? ({m_hi, m_lo} != 64'h0) : (m_lo != 32'h0);
      assign hits[i] = enabled && !upper[i] && (io_bar == want_io)
                       && ((addr & em) == (eb & em));
      assign ap[i]   = bit_len64(is64[i] ? ~{m_hi, m_lo} : {32'h0, ~m_lo});
    end
  endgenerate

  // a BAR right after an unpaired 64-bit BAR is the upper half of that pair
  always_comb begin
    logic prev;
    prev = 1'b0;
    for (int k = 0; k < NUM_BAR; k++) begin
      upper[k] = (k > 0) && is64[(k > 0) ? k - 1 : 0] && !prev;
      prev     = upper[k];
    end
  end

  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    aperture = '0;
    for (int k = NUM_BAR - 1; k >= 0; k--) begin
      if (hits[k]) begin
        hit      = 1'b1;
        idx      = BAR_W'(k);
        aperture = ap[k];
      end
    end
  end

  logic [NUM_BAR-1:0] below_sel;
  assign below_sel = ({{(NUM_BAR-1){1'b0}}, 1'b1} << idx) - 1'b1;

  // R9: the chosen BAR hits and no lower-index BAR does
  p_lowest_bar_r9: assert property (@(posedge clk) disable iff (rst)
    hit |-> (hits[idx] && ((hits & below_sel) == '0)));

  // R10: the upper half of a 64-bit pair never reports a hit
  p_upper_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (hits & upper) == '0);

endmodule

// File: rtl/ep_inbound_router.sv
module ep_inbound_router
  import ep_rt_pkg::*;
#(
  parameter int NUM_FUNC = 2,
  parameter int NUM_BAR  = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            in_valid,
  input  logic [7:0]                      in_fmt_type,
  input  logic [15:0]                     in_dest_id,
  input  logic [15:0]                     in_req_id,
  input  logic [63:0]                     in_addr,
  input  logic [2:0]                      in_cpl_status,
  input  logic                            cfg_space_en,
  input  logic [4:0]                      dev_num,
  input  logic [NUM_FUNC*NUM_BAR*32-1:0]  bar_base,
  input  logic [NUM_FUNC*NUM_BAR*32-1:0]  bar_mask,
  output logic                            out_valid,
  output logic [2:0]                      out_route,
  output logic [2:0]                      out_func,
  output logic [$clog2(NUM_BAR)-1:0]      out_bar,
  output logic [6:0]                      out_aperture,
  output logic                            out_bad_status,
  output logic                            out_gen_ur,
  output logic                            out_gen_crs,
  output logic [7:0]                      bus_num
);
  localparam int BAR_W    = $clog2(NUM_BAR);
  localparam int FUNC_BIT = NUM_BAR * 32;

  kind_e kind;
  ep_hdr_decode u_dec (.fmt_type(in_fmt_type), .kind(kind));

  logic want_io;
  assign want_io = (kind == K_IO_RD) || (kind == K_IO_WR);

  logic [NUM_FUNC-1:0] f_hit;
  logic [BAR_W-1:0]    f_idx [NUM_FUNC];
  logic [6:0]          f_ap  [NUM_FUNC];

  genvar f;
  generate
    for (f = 0; f < NUM_FUNC; f++) begin : g_fn
      ep_bar_match #(.NUM_BAR(NUM_BAR), .BAR_W(BAR_W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .addr     (in_addr),
        .want_io  (want_io),
        .bases    (bar_base[f*FUNC_BIT +: FUNC_BIT]),
        .masks    (bar_mask[f*FUNC_BIT +: FUNC_BIT]),
        .hit      (f_hit[f]),
        .idx      (f_idx[f]),
        .aperture (f_ap[f])
      );
    end
  endgenerate

  logic             any_hit;
  logic [2:0]       hit_fn;
  logic [BAR_W-1:0] hit_bar;
  logic [6:0]       hit_ap;
  always_comb begin
    any_hit = 1'b0;
    hit_fn  = '0;
    hit_bar = '0;
    hit_ap  = '0;
    for (int k = NUM_FUNC - 1; k >= 0; k--) begin
      if (f_hit[k]) begin
        any_hit = 1'b1;
        hit_fn  = 3'(k);
        hit_bar = f_idx[k];
        hit_ap  = f_ap[k];
      end
    end
  end

  logic [7:0] dst_bus, rq_bus;
  logic [4:0] dst_dev, rq_dev;
  logic [2:0] dst_fn, rq_fn;
  assign {dst_bus, dst_dev, dst_fn} = in_dest_id;
  assign {rq_bus, rq_dev, rq_fn}    = in_req_id;

  route_e           n_route;
  logic [2:0]       n_func;
  logic [BAR_W-1:0] n_bar;
  logic [6:0]       n_ap;
  logic             n_bad, n_ur, n_crs;
  logic [7:0]       n_bus;

  always_comb begin
    n_route = RT_DROP;
    n_func  = '0;
    n_bar   = '0;
    n_ap    = '0;
    n_bad   = 1'b0;
    n_ur    = 1'b0;
    n_crs   = 1'b0;
    n_bus   = bus_num;
    case (kind)
      K_CFG0: begin
        if (!cfg_space_en) begin
          n_crs = 1'b1;
        end else if (dst_dev == dev_num) begin
          n_bus = dst_bus;
          if (32'(dst_fn) < NUM_FUNC) begin
            n_route = RT_CONFIG;
            n_func  = dst_fn;
          end else begin
            n_ur = 1'b1;
          end
        end else begin
          n_ur = 1'b1;
        end
      end
      K_CFG1: n_route = RT_MALFORMED;
      K_CPL: begin
        if (rq_bus == bus_num && rq_dev == dev_num && 32'(rq_fn) < NUM_FUNC) begin
          n_route = RT_CPL;
          n_func  = rq_fn;
          n_bad   = (in_cpl_status != 3'd0);
        end
      end
      K_MRD, K_MWR, K_IO_RD, K_IO_WR: begin
        if (any_hit) begin
          n_route = want_io ? RT_IO : RT_MEM;
          n_func  = hit_fn;
          n_bar   = hit_bar;
          n_ap    = hit_ap;
        end else if (kind != K_MWR) begin
          n_ur = 1'b1;
        end
      end
      default: n_ur = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_route      <= RT_DROP;
      out_func       <= '0;
      out_bar        <= '0;
      out_aperture   <= '0;
      out_bad_status <= 1'b0;
      out_gen_ur     <= 1'b0;
      out_gen_crs    <= 1'b0;
      bus_num        <= '0;
    end else begin
      out_valid      <= in_valid;
      out_route      <= in_valid ? n_route : RT_DROP;
      out_func       <= in_valid ? n_func  : '0;
      out_bar        <= in_valid ? n_bar   : '0;
      out_aperture   <= in_valid ? n_ap    : '0;
      out_bad_status <= in_valid && n_bad;
      out_gen_ur     <= in_valid && n_ur;
      out_gen_crs    <= in_valid && n_crs;
      if (in_valid) bus_num <= n_bus;
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_gen_ur && !out_gen_crs));
  p_bus_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && kind == K_CFG0) |=> $stable(bus_num));
  p_crs_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == K_CFG0 && !cfg_space_en) |=> (out_gen_crs && $stable(bus_num)));
  p_cfg1_malformed_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == K_CFG1) |=> (out_route == RT_MALFORMED && !out_gen_ur && !out_gen_crs));
  p_cpl_no_ur_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == K_CPL) |=> !out_gen_ur);
  p_bad_cpl_only_r7: assert property (@(posedge clk) disable iff (rst)
    out_bad_status |-> (out_route == RT_CPL));
  p_mwr_no_ur_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind == K_MWR) |=> !out_gen_ur);

endmodule

// File: tb/ep_inbound_router_test.sv
`timescale 1ns/1ps
module ep_inbound_router_test;
  localparam int NF = 2;
  localparam int NB = 6;
  localparam int BW = $clog2(NB);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, in_valid, cfg_en;
  logic [7:0]  in_ft;
  logic [15:0] in_did, in_rid;
  logic [63:0] in_addr;
  logic [2:0]  in_st;
  logic [4:0]  dev_num;
  logic [NF*NB*32-1:0] bar_base, bar_mask;
  logic          out_valid, out_bad, out_ur, out_crs;
  logic [2:0]    out_route, out_func;
  logic [BW-1:0] out_bar;
  logic [6:0]    out_ap;
  logic [7:0]    bus_num;

  logic [31:0] tb_base [NF][NB];
  logic [31:0] tb_mask [NF][NB];
  always_comb
    for (int f = 0; f < NF; f++)
      for (int b = 0; b < NB; b++) begin
        bar_base[(f*NB+b)*32 +: 32] = tb_base[f][b];
        bar_mask[(f*NB+b)*32 +: 32] = tb_mask[f][b];
      end

  ep_inbound_router #(.NUM_FUNC(NF), .NUM_BAR(NB)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt_type(in_ft),
    .in_dest_id(in_did), .in_req_id(in_rid), .in_addr(in_addr),
    .in_cpl_status(in_st), .cfg_space_en(cfg_en), .dev_num(dev_num),
    .bar_base(bar_base), .bar_mask(bar_mask), .out_valid(out_valid),
    .out_route(out_route), .out_func(out_func), .out_bar(out_bar),
    .out_aperture(out_ap), .out_bad_status(out_bad), .out_gen_ur(out_ur),
    .out_gen_crs(out_crs), .bus_num(bus_num));

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int     e_valid, e_route, e_func, e_bar, e_ap, e_bad, e_ur, e_crs;
  int     m_bus = 0;
  string  e_tag = "R1";

  task automatic chk(string tag, string what, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic compare();
    chk("R1", "valid", out_valid, e_valid);
    chk(e_tag, "route", out_route, e_route);
    chk(e_tag, "func", out_func, e_func);
    chk(e_tag, "bar", out_bar, e_bar);
    chk(e_tag, "aperture", out_ap, e_ap);
    chk(e_tag, "bad_status", out_bad, e_bad);
    chk(e_tag, "gen_ur", out_ur, e_ur);
    chk(e_tag, "gen_crs", out_crs, e_crs);
    chk(e_tag, "bus_num", bus_num, m_bus);
  endtask

  function automatic int bitlen(longint unsigned v);
    int r = 0;
    for (int i = 0; i < 64; i++) if (v[i]) r = i + 1;
    return r;
  endfunction

  // behavioural expectation for one header
  task automatic model(input bit v, input bit en, input logic [7:0] ft,
                       input logic [15:0] did, input logic [15:0] rid,
                       input logic [63:0] a, input logic [2:0] st);
    bit is_rd, is_wr, is_io, found;
    e_valid = v; e_route = 0; e_func = 0; e_bar = 0; e_ap = 0;
    e_bad = 0; e_ur = 0; e_crs = 0;
    if (!v) return;
    is_rd = (ft == 8'h00 || ft == 8'h20);
    is_wr = (ft == 8'h40 || ft == 8'h60);
    is_io = (ft == 8'h02 || ft == 8'h42);
    if (ft == 8'h04 || ft == 8'h44) begin
      if (!en) e_crs = 1;
      else if (did[7:3] == dev_num) begin
        m_bus = did[15:8];
        if (did[2:0] < NF) begin e_route = 1; e_func = did[2:0]; end
        else e_ur = 1;
      end else e_ur = 1;
    end else if (ft == 8'h05 || ft == 8'h45) begin
      e_route = 5;
    end else if (ft == 8'h0A || ft == 8'h4A || ft == 8'h0B || ft == 8'h4B) begin
      if (rid[15:8] == m_bus && rid[7:3] == dev_num && rid[2:0] < NF) begin
        e_route = 2; e_func = rid[2:0]; e_bad = (st != 0);
      end
    end else if (is_rd || is_wr || is_io) begin
      found = 0;
      for (int f = 0; f < NF && !found; f++) begin
        int b = 0;
        while (b < NB && !found) begin
          longint unsigned bs, mk, raw;
          logic [31:0] lo = tb_base[f][b];
          int step = 1;
          bit kind_io = lo[0];
          if (!lo[0] && lo[2:1] == 2'b10 && b + 1 < NB) begin
            raw = {tb_mask[f][b+1], tb_mask[f][b]};
            bs  = {tb_base[f][b+1], lo & 32'hFFFF_FFF0};
            mk  = {tb_mask[f][b+1], tb_mask[f][b] & 32'hFFFF_FFF0};
            step = 2;
          end else begin
            raw = {32'h0, tb_mask[f][b]};
            bs  = {32'h0, lo & (kind_io ? 32'hFFFF_FFFC : 32'hFFFF_FFF0)};
            mk  = {32'hFFFF_FFFF, tb_mask[f][b] & (kind_io ? 32'hFFFF_FFFC : 32'hFFFF_FFF0)};
          end
          if (raw != 0 && kind_io == is_io && (a & mk) == (bs & mk)) begin
            found = 1; e_route = is_io ? 3 : 4; e_func = f; e_bar = b;
            e_ap = bitlen(step == 2 ? ~raw : {32'h0, ~tb_mask[f][b]});
          end
          b += step;
        end
      end
      if (!found && !is_wr) e_ur = 1;
    end else e_ur = 1;
  endtask

  task automatic send(string tag, bit v, bit en, logic [7:0] ft, logic [15:0] did,
                      logic [15:0] rid, logic [63:0] a, logic [2:0] st);
    @(negedge clk);
    compare();
    in_valid = v; cfg_en = en; in_ft = ft; in_did = did; in_rid = rid;
    in_addr = a; in_st = st;
    e_tag = tag;
    model(v, en, ft, did, rid, a, st);
  endtask

  function automatic logic [15:0] id(int bus, int dev, int fn);
    return {8'(bus), 5'(dev), 3'(fn)};
  endfunction

  initial begin
    for (int f = 0; f < NF; f++)
      for (int b = 0; b < NB; b++) begin tb_base[f][b] = 0; tb_mask[f][b] = 0; end
    tb_base[0][0] = 32'h8000_0000; tb_mask[0][0] = 32'hFFFF_F000;
    tb_base[0][1] = 32'h0000_1001; tb_mask[0][1] = 32'hFFFF_FF00;
    tb_base[0][2] = 32'h0010_0004; tb_mask[0][2] = 32'hFFF0_0000;
    tb_base[0][3] = 32'h0000_0001; tb_mask[0][3] = 32'hFFFF_FFFF;
    tb_base[1][0] = 32'h8000_0000; tb_mask[1][0] = 32'hFFFF_0000;
    tb_base[1][1] = 32'h9000_0000; tb_mask[1][1] = 32'hFFFF_FF00;
    tb_base[1][2] = 32'h9000_0000; tb_mask[1][2] = 32'hFFFF_0000;
    dev_num = 5'd3;
    rst = 1; in_valid = 0; cfg_en = 0; in_ft = 0; in_did = 0; in_rid = 0;
    in_addr = 0; in_st = 0;
    model(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    compare();                       // R1 reset state
    rst = 0;
    send("R1", 0, 1, 0, 0, 0, 0, 0);
    send("R4", 1, 0, 8'h04, id(8'h12, 3, 0), 0, 0, 0);
    send("R2", 1, 1, 8'h44, id(8'h12, 3, 1), 0, 0, 0);
    send("R2", 1, 1, 8'h04, id(8'h34, 3, 5), 0, 0, 0);
    send("R3", 1, 1, 8'h04, id(8'h55, 4, 0), 0, 0, 0);
    send("R4", 1, 0, 8'h44, id(8'h77, 3, 0), 0, 0, 0);
    send("R5", 1, 1, 8'h05, id(8'h34, 3, 0), 0, 0, 0);
    send("R5", 1, 0, 8'h45, id(8'h34, 3, 0), 0, 0, 0);
    send("R6", 1, 1, 8'h0A, 0, id(8'h34, 3, 1), 0, 0);
    send("R7", 1, 1, 8'h4A, 0, id(8'h34, 3, 0), 0, 3'd1);
    send("R7", 1, 1, 8'h0B, 0, id(8'h34, 3, 1), 0, 3'd4);
    send("R6", 1, 1, 8'h4B, 0, id(8'h34, 3, 0), 0, 0);
    send("R6", 1, 1, 8'h0A, 0, id(8'h35, 3, 0), 0, 0);
    send("R6", 1, 1, 8'h4A, 0, id(8'h34, 3, 2), 0, 3'd1);
    send("R6", 1, 1, 8'h0A, 0, id(8'h34, 2, 0), 0, 0);
    send("R9", 1, 1, 8'h00, 0, 0, 64'h8000_0100, 0);
    send("R9", 1, 1, 8'h40, 0, 0, 64'h8000_8000, 0);
    send("R9", 1, 1, 8'h00, 0, 0, 64'h9000_0010, 0);
    send("R9", 1, 1, 8'h00, 0, 0, 64'h9000_0210, 0);
    send("R8", 1, 1, 8'h02, 0, 0, 64'h0000_1010, 0);
    send("R8", 1, 1, 8'h42, 0, 0, 64'h0000_10FC, 0);
    send("R8", 1, 1, 8'h00, 0, 0, 64'h0000_1010, 0);
    send("R8", 1, 1, 8'h42, 0, 0, 64'h8000_0100, 0);
    send("R11", 1, 1, 8'h20, 0, 0, 64'h1_0010_0040, 0);
    send("R10", 1, 1, 8'h60, 0, 0, 64'h1_001F_FFFC, 0);
    send("R10", 1, 1, 8'h20, 0, 0, 64'h0_0010_0040, 0);
    send("R10", 1, 1, 8'h02, 0, 0, 64'h0, 0);
    send("R12", 1, 1, 8'h60, 0, 0, 64'h2_0000_0000, 0);
    send("R12", 1, 1, 8'h20, 0, 0, 64'h2_0000_0000, 0);
    send("R12", 1, 1, 8'h02, 0, 0, 64'h0000_5000, 0);
    send("R8", 1, 1, 8'h00, 0, 0, 64'h1_8000_0100, 0);
    send("R13", 1, 1, 8'h30, 0, 0, 0, 0);
    send("R13", 1, 1, 8'h01, 0, 0, 64'h8000_0100, 0);
    send("R13", 1, 1, 8'h21, 0, 0, 64'h8000_0100, 0);
    send("R1", 0, 1, 8'h00, 0, 0, 64'h8000_0100, 0);
    send("R3", 1, 1, 8'h0A, 0, id(8'h34, 3, 0), 0, 0);
    send("R1", 0, 1, 0, 0, 0, 0, 0);
    send("R1", 0, 1, 0, 0, 0, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule